// File: doc/BRIEF.md
# TDM Stereo Slot Port

This block is the serial side of an audio path that talks to an external codec acting as bus master. The codec drives a bit clock and a one-bit-wide frame sync; the block only listens to them. It oversamples both through synchronizers in the system clock domain. Received serial words are collected into a four-entry slot buffer. The first two slots carry the left and right samples, and the later slots carry whatever the codec sends when its frame is longer.

On the transmit side, the next stereo pair is handed over with a load strobe. At each frame start it is copied into a four-entry transmit buffer, together with two control words, and shifted out MSB first. Both slot pointers return to slot 0 at every frame sync. A frame that ends early therefore cannot leave the block misaligned for the next one.

Downstream logic waits for the frame-done strobe and then reads the stereo pair. Sticky flags report a missed transmit load (underrun) and a receive word that had no free slot (overrun). Each flag is cleared by its own input.

Top module: `tdm_slot_port`

## Requirements
- R1: A frame sync seen high at a bit-clock falling edge marks the start of a frame. The serial input is sampled on bit-clock falling edges. The first data bit is the one sampled at the next falling edge. Words are 16 bits, MSB first, so a 32-clock frame carries slot 0 (left) and then slot 1 (right).
- R2: Each received word is stored left-justified in a 24-bit container. The sample MSB is at bit 23 and bits 7:0 are zero. Slot k occupies `rx_slots[24k+23:24k]`.
- R3: `frame_done` pulses high for exactly one system clock each time slot 1 (right) of a frame has been stored. It pulses at no other time.
- R4: A pair given with `tx_load` before a frame sync is sent in that frame: left in bit clocks 0..15 and right in bit clocks 16..31. Both words go MSB first, and the output changes after bit-clock rising edges.
- R5: When the codec frame is longer than 32 bit clocks, transmit slot 2 sends `ctrl_words[15:0]` and slot 3 sends `ctrl_words[31:16]`. Every bit after slot 3 is sent as zero.
- R6: When the codec frame is longer than 32 bit clocks, received slots 2 and 3 are stored in the receive buffer in the same way as the audio slots.
- R7: Every frame sync returns both slot pointers to slot 0 and discards any partly received word. After a frame sync arrives mid-word, slot 1 keeps its previous content and the next frame is stored from slot 0 again.
- R8: If no `tx_load` has occurred since the previous frame sync, the frame sends zeros in slots 0 and 1 and `underrun` is set. `underrun` stays set until `clr_underrun` is pulsed.
- R9: If a fifth word completes within one frame, it is discarded, slot 3 keeps the fourth word, and `overrun` is set. `overrun` stays set until `clr_overrun` is pulsed.
- R10: While `rst` is high, `sdout`, `frame_done`, `underrun`, `overrun` and all of `rx_slots` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Bit clock from the codec |
| fsync_in | input | 1 | Frame sync from the codec, active high |
| sdin_in | input | 1 | Serial data from the codec |
| sdout | output | 1 | Serial data to the codec |
| tx_load | input | 1 | Strobe that takes the next left/right pair |
| tx_left | input | 16 | Left sample for the next frame |
| tx_right | input | 16 | Right sample for the next frame |
| ctrl_words | input | 32 | Control words for slot 2 (low half) and slot 3 (high half) |
| clr_underrun | input | 1 | Clears the underrun flag |
| clr_overrun | input | 1 | Clears the overrun flag |
| rx_slots | output | 96 | Receive buffer, four 24-bit left-justified slots |
| frame_done | output | 1 | One-cycle pulse when the right sample is stored |
| underrun | output | 1 | Sticky missed-transmit-load flag |
| overrun | output | 1 | Sticky receive-overflow flag |

## Verification
The hardest conditions to reach are those that need a misbehaving codec. Overflow needs a frame with more than four words. Pointer recovery needs a frame sync that lands in the middle of a word. The bench's bit-clock driver takes the frame length as an argument and puts the sync on the last bit of any length. This lets it produce 24-, 32-, 64- and 80-clock frames back to back. Underrun is forced by skipping the load strobe for one frame, so the following frame must go out as zeros.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_CONT_W   = 24;
    localparam int DEF_SLOTS    = 4;
    localparam int DEF_STAGES   = 2;

    // Pin activity after synchronization, one system clock per event
    typedef struct packed {
        logic rise;   // bit clock went high
        logic fall;   // bit clock went low
        logic fs;     // frame sync level, aligned with the edge flags
        logic din;    // serial input level, aligned with the edge flags
    } pin_evt_t;

endpackage

// File: rtl/tdm_pin_sync.sv
module tdm_pin_sync
    import tdm_port_pkg::*;
#(
    parameter int STAGES = DEF_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_in,
    input  logic     fsync_in,
    input  logic     sdin_in,
    output pin_evt_t evt
);

    localparam int LANES = 3;

    logic [LANES-1:0] stage [STAGES];
    logic             bclk_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= {bclk_in, fsync_in, sdin_in};
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= stage[STAGES-1][2];
    end

    always_comb begin
        evt.rise = stage[STAGES-1][2] & ~bclk_prev;
        evt.fall = ~stage[STAGES-1][2] & bclk_prev;
        evt.fs   = stage[STAGES-1][1];
        evt.din  = stage[STAGES-1][0];
    end

endmodule

// File: rtl/tdm_rx_slots.sv
module tdm_rx_slots
    import tdm_port_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CONT_W   = DEF_CONT_W,
    parameter int SLOTS    = DEF_SLOTS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bit_fall,
    input  logic                      fs_lvl,
    input  logic                      din,
    input  logic                      clr_overrun,
    output logic [SLOTS*CONT_W-1:0]   rx_slots,
    output logic                      frame_done,
    output logic                      overrun
);

    localparam int PTR_W = $clog2(SLOTS + 1);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int BIT_W = $clog2(SAMPLE_W);
    localparam int PAD_W = CONT_W - SAMPLE_W;

    logic                  armed;
    logic [BIT_W-1:0]      bitcnt;
    logic [PTR_W-1:0]      ptr;
    logic [SAMPLE_W-2:0]   shreg;
    logic [CONT_W-1:0]     slot_q [SLOTS];

    logic [SAMPLE_W-1:0]   next_word;
    logic                  word_end;

    assign next_word = {shreg, din};
    assign word_end  = (bitcnt == BIT_W'(SAMPLE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            bitcnt     <= '0;
            ptr        <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            overrun    <= 1'b0;
            for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
        end else begin
            frame_done <= 1'b0;
            if (clr_overrun) overrun <= 1'b0;
            if (bit_fall) begin
                if (armed) begin
                    shreg  <= next_word[SAMPLE_W-2:0];
                    bitcnt <= bitcnt + 1'b1;
                    if (word_end) begin
                        bitcnt <= '0;
                        if (ptr < PTR_W'(SLOTS)) begin
                            slot_q[ptr[IDX_W-1:0]] <= {next_word, {PAD_W{1'b0}}};
                            ptr <= ptr + 1'b1;
                            if (ptr == PTR_W'(1)) frame_done <= 1'b1;
                        end else begin
                            overrun <= 1'b1;
                        end
                    end
                end
                // frame start: pointer back to base, partial word dropped
                if (fs_lvl) begin
                    armed  <= 1'b1;
                    bitcnt <= '0;
                    ptr    <= '0;
                end
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_out
        assign rx_slots[g*CONT_W +: CONT_W] = slot_q[g];
    end

endmodule

// File: rtl/tdm_tx_slots.sv
module tdm_tx_slots
    import tdm_port_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int SLOTS    = DEF_SLOTS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bit_rise,
    input  logic                           bit_fall,
    input  logic                           fs_lvl,
    input  logic                           tx_load,
    input  logic [SAMPLE_W-1:0]            tx_left,
    input  logic [SAMPLE_W-1:0]            tx_right,
    input  logic [(SLOTS-2)*SAMPLE_W-1:0]  ctrl_words,
    input  logic                           clr_underrun,
    output logic                           sdout,
    output logic                           underrun
);

    localparam int PTR_W = $clog2(SLOTS + 1);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int BIT_W = $clog2(SAMPLE_W);

    logic                 armed;
    logic                 loaded;
    logic [SAMPLE_W-1:0]  pend_l, pend_r;
    logic [SAMPLE_W-1:0]  tbuf [SLOTS];
    logic [BIT_W-1:0]     bitcnt;
    logic [PTR_W-1:0]     ptr;
    logic [BIT_W-1:0]     bit_sel;

    assign bit_sel = BIT_W'(SAMPLE_W - 1) - bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            loaded   <= 1'b0;
            pend_l   <= '0;
            pend_r   <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            sdout    <= 1'b0;
            underrun <= 1'b0;
            for (int k = 0; k < SLOTS; k++) tbuf[k] <= '0;
        end else begin
            if (clr_underrun) underrun <= 1'b0;
            if (tx_load) begin
                pend_l <= tx_left;
                pend_r <= tx_right;
                loaded <= 1'b1;
            end
            if (bit_fall && fs_lvl) begin
                armed  <= 1'b1;
                bitcnt <= '0;
                ptr    <= '0;
                if (loaded) begin
                    tbuf[0] <= pend_l;
                    tbuf[1] <= pend_r;
                end else begin
                    tbuf[0]  <= '0;
                    tbuf[1]  <= '0;
                    underrun <= 1'b1;
                end
                // a load in this very cycle belongs to the following frame
                loaded <= tx_load;
                for (int k = 2; k < SLOTS; k++)
                    tbuf[k] <= ctrl_words[(k-2)*SAMPLE_W +: SAMPLE_W];
            end else if (bit_rise && armed) begin
                if (ptr < PTR_W'(SLOTS)) sdout <= tbuf[ptr[IDX_W-1:0]][bit_sel];
                else                     sdout <= 1'b0;
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == BIT_W'(SAMPLE_W - 1)) begin
                    bitcnt <= '0;
                    if (ptr < PTR_W'(SLOTS)) ptr <= ptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tdm_port_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int CONT_W   = DEF_CONT_W,
    parameter int SLOTS    = DEF_SLOTS,
    parameter int STAGES   = DEF_STAGES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bclk_in,
    input  logic                           fsync_in,
    input  logic                           sdin_in,
    output logic                           sdout,
    input  logic                           tx_load,
    input  logic [SAMPLE_W-1:0]            tx_left,
    input  logic [SAMPLE_W-1:0]            tx_right,
    input  logic [(SLOTS-2)*SAMPLE_W-1:0]  ctrl_words,
    input  logic                           clr_underrun,
    input  logic                           clr_overrun,
    output logic [SLOTS*CONT_W-1:0]        rx_slots,
    output logic                           frame_done,
    output logic                           underrun,
    output logic                           overrun
);

    pin_evt_t evt;

    tdm_pin_sync #(.STAGES(STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .bclk_in  (bclk_in),
        .fsync_in (fsync_in),
        .sdin_in  (sdin_in),
        .evt      (evt)
    );

    tdm_rx_slots #(.SAMPLE_W(SAMPLE_W), .CONT_W(CONT_W), .SLOTS(SLOTS)) i_rx (
        .clk         (clk),
        .rst         (rst),
        .bit_fall    (evt.fall),
        .fs_lvl      (evt.fs),
        .din         (evt.din),
        .clr_overrun (clr_overrun),
        .rx_slots    (rx_slots),
        .frame_done  (frame_done),
        .overrun     (overrun)
    );

    tdm_tx_slots #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) i_tx (
        .clk          (clk),
        .rst          (rst),
        .bit_rise     (evt.rise),
        .bit_fall     (evt.fall),
        .fs_lvl       (evt.fs),
        .tx_load      (tx_load),
        .tx_left      (tx_left),
        .tx_right     (tx_right),
        .ctrl_words   (ctrl_words),
        .clr_underrun (clr_underrun),
        .sdout        (sdout),
        .underrun     (underrun)
    );

endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk (
    input logic clk,
    input logic rst,
    input logic sdout,
    input logic frame_done,
    input logic underrun,
    input logic overrun,
    input logic clr_underrun,
    input logic clr_overrun
);

    // R3: the frame-done strobe never lasts two cycles
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R8: underrun holds until cleared
    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr_underrun) |=> underrun);

    // R9: overrun holds until cleared
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_overrun) |=> overrun);

    // R10: reset quiets every status output and the serial line
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!frame_done && !underrun && !overrun && !sdout));

endmodule

bind tdm_slot_port tdm_slot_port_chk i_chk (.*);

// File: tb/test_tdm_slot_port.sv
module test_tdm_slot_port;

    localparam int W    = 16;
    localparam int C    = 24;
    localparam int S    = 4;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst = 1'b1;
    logic             bclk_in = 1'b0, fsync_in = 1'b0, sdin_in = 1'b0;
    logic             sdout;
    logic             tx_load = 1'b0;
    logic [W-1:0]     tx_left = '0, tx_right = '0;
    logic [2*W-1:0]   ctrl_words = {16'hC0DE, 16'h0B0E};
    logic             clr_underrun = 1'b0, clr_overrun = 1'b0;
    logic [S*C-1:0]   rx_slots;
    logic             frame_done, underrun, overrun;

    tdm_slot_port i_tdm_slot_port (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in), .sdin_in(sdin_in),
        .sdout(sdout), .tx_load(tx_load), .tx_left(tx_left), .tx_right(tx_right),
        .ctrl_words(ctrl_words), .clr_underrun(clr_underrun), .clr_overrun(clr_overrun),
        .rx_slots(rx_slots), .frame_done(frame_done), .underrun(underrun), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_l_q[$];
    logic [W-1:0] exp_r_q[$];
    logic [W-1:0] cur_l = '0, cur_r = '0, pend_l = '0, pend_r = '0;
    bit           pend_ok = 1'b0;
    bit           exp_under = 1'b0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_clock(input logic d, input logic fs, output logic so);
        @(negedge clk);
        bclk_in = 1'b1; sdin_in = d; fsync_in = fs;
        repeat (HALF) @(negedge clk);
        bclk_in = 1'b0;
        so = sdout;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic load_pair(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        tx_left = l; tx_right = r; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        pend_l = l; pend_r = r; pend_ok = 1'b1;
    endtask

    // driver: one codec frame of len bit clocks, sync on its last bit
    task automatic run_frame(input int len, input logic [5*W-1:0] words, input bit do_load,
                             input logic [W-1:0] nl, input logic [W-1:0] nr, input string tag);
        logic [127:0] cap;
        logic [127:0] expv;
        logic         so;
        cap = '0; expv = '0;
        if (len >= 2*W) begin
            exp_l_q.push_back(words[W-1:0]);
            exp_r_q.push_back(words[2*W-1:W]);
        end
        if (do_load) load_pair(nl, nr);
        for (int i = 0; i < len; i++) begin
            int s;
            int b;
            logic d;
            logic [W-1:0] tw;
            s  = i / W;
            b  = W - 1 - (i % W);
            d  = (s < 5) ? words[s*W + b] : 1'b0;
            tw = (s == 0) ? cur_l : (s == 1) ? cur_r :
                 (s == 2) ? ctrl_words[W-1:0] : (s == 3) ? ctrl_words[2*W-1:W] : '0;
            expv = {expv[126:0], tw[b]};
            bit_clock(d, (i == len - 1), so);
            cap = {cap[126:0], so};
        end
        check({tag, " tx serial frame"}, cap, expv);
        if (!pend_ok) exp_under = 1'b1;
        cur_l = pend_ok ? pend_l : '0;
        cur_r = pend_ok ? pend_r : '0;
        pend_ok = 1'b0;
    endtask

    // monitor: each frame-done strobe pops one expected stereo pair
    always @(negedge clk) begin
        if (!rst && frame_done) begin
            if (exp_l_q.size() == 0) begin
                check("R3 unexpected frame_done", 128'd1, 128'd0);
            end else begin
                logic [W-1:0] el, er;
                el = exp_l_q.pop_front();
                er = exp_r_q.pop_front();
                check("R1 R2 left slot", rx_slots[C-1:0], {el, 8'h00});
                check("R1 R2 right slot", rx_slots[2*C-1:C], {er, 8'h00});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic so;
        repeat (4) @(negedge clk);
        check("R10 reset sdout/flags", {sdout, frame_done, underrun, overrun}, 4'b0);
        check("R10 reset rx_slots", rx_slots, '0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // first frame sync, with a pair already loaded
        load_pair(16'hF00D, 16'h0BAD);
        bit_clock(1'b0, 1'b1, so);
        cur_l = pend_l; cur_r = pend_r; pend_ok = 1'b0;

        run_frame(32, {16'h0, 16'h0, 16'h0, 16'hABCD, 16'h1234}, 1, 16'h1111, 16'hEEEE, "R4 A");
        check("R8 no underrun when loaded", underrun, 0);
        run_frame(32, {16'h0, 16'h0, 16'h0, 16'h5555, 16'hAAAA}, 1, 16'hA5A5, 16'h5A5A, "R4 B");

        run_frame(64, {16'h0, 16'h7E81, 16'hC3A5, 16'h0001, 16'h8000}, 1, 16'h8001, 16'h7FFE, "R5 C");
        check("R6 rx slot 2", rx_slots[3*C-1:2*C], {16'hC3A5, 8'h00});
        check("R6 rx slot 3", rx_slots[4*C-1:3*C], {16'h7E81, 8'h00});
        check("R9 no overrun at four words", overrun, 0);

        run_frame(80, {16'hDEAD, 16'h2468, 16'h1357, 16'h0F0F, 16'hFFFF}, 1, 16'h00FF, 16'hFF00, "R5 D");
        check("R9 overrun set", overrun, 1);
        check("R9 slot 3 keeps fourth word", rx_slots[4*C-1:3*C], {16'h2468, 8'h00});
        @(negedge clk); clr_overrun = 1'b1;
        @(negedge clk); clr_overrun = 1'b0;
        @(negedge clk);
        check("R9 overrun cleared", overrun, 0);

        run_frame(24, {16'h0, 16'h0, 16'h0, 16'h9999, 16'h4C4C}, 1, 16'h3333, 16'hCCCC, "R7 E");
        check("R7 short frame slot 0", rx_slots[C-1:0], {16'h4C4C, 8'h00});
        check("R7 partial word dropped", rx_slots[2*C-1:C], {16'h0F0F, 8'h00});

        run_frame(32, {16'h0, 16'h0, 16'h0, 16'hFDB9, 16'h0246}, 0, 16'h0, 16'h0, "R7 F");
        check("R8 underrun set", underrun, exp_under);
        run_frame(32, {16'h0, 16'h0, 16'h0, 16'h8001, 16'h7FFF}, 1, 16'h9876, 16'h5432, "R8 G");
        check("R8 underrun sticky", underrun, 1);
        @(negedge clk); clr_underrun = 1'b1;
        @(negedge clk); clr_underrun = 1'b0;
        @(negedge clk);
        check("R8 underrun cleared", underrun, 0);

        run_frame(32, {16'h0, 16'h0, 16'h0, 16'hC3C3, 16'h3C3C}, 0, 16'h0, 16'h0, "R4 H");
        check("R8 underrun after unloaded frame", underrun, 1);
        check("R9 overrun stays clear", overrun, 0);
        repeat (20) @(negedge clk);
        check("R3 one frame_done per full frame", exp_l_q.size(), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule